// File: doc/BRIEF.md
# Critical-Row-First Cache Line Refill Engine

This block refills one cache line over a pipelined Wishbone master port after a load miss. The line holds several 64-bit rows, and each row is one bus word. The engine fetches the row the missing load asked for first. It then walks forward through the remaining rows of the line and wraps at the line boundary, so every row is fetched exactly once.

The requested row goes straight to the load through a forwarding register, one cycle after its acknowledge arrives. The load does not wait for the data RAM. The engine keeps one valid flag per row of the line in flight. The surrounding cache uses these flags to finish later loads to the same line as soon as their row has landed. Every returned row is also presented as a data-RAM write. When the final acknowledge arrives, the engine asks for the tag to be written and goes idle.

A zero-line request runs the same row order as a burst of writes carrying zero data with all byte lanes enabled. Zeros go into the data RAM, and the tag write at the end allocates the line. The request is made by pulsing `reqValid` with the row-granular miss address. Pulses while `busy` is high are dropped.

Top module: `refill_engine`

## Requirements
- R1: A request accepted while idle raises `wbCyc` and `wbStb` on the next cycle. In that cycle `wbWe` equals the zero-line flag, `wbSel` is all ones (8'hFF), and `wbAdr` is the line base plus the requested row times 8.
- R2: After each cycle with `wbStb` high and `wbStall` low, the next address is the following row modulo the line. The address holds while stalled. After exactly ROWS accepted transfers, `wbStb` drops.
- R3: For a load refill, `loadDone` pulses for one cycle, one cycle after the first acknowledge. `loadData` carries that acknowledge's `wbDatI`.
- R4: The k-th acknowledge (k from 0) belongs to row (critical row + k) mod ROWS. Bit `rowValid[row]` is set in the cycle after that acknowledge and stays set until the next refill starts.
- R5: All `rowValid` bits are zero in the first cycle of a new refill.
- R6: A zero-line refill drives `wbWe`=1 and `wbDatO`=0 and writes zeros to the RAM. Its `loadDone` pulses once, one cycle after the last acknowledge, and not early.
- R7: Every acknowledge causes a one-cycle `ramWe` pulse on the next cycle. The pulse carries `ramRow` set to that acknowledge's row and `ramData` set to its `wbDatI`, or zero for a zero-line refill.
- R8: One cycle after the last acknowledge, `tagWe` pulses with `tagLine` set to the line number. In the same cycle `wbCyc` and `busy` are low.
- R9: A request presented while `busy` is high is ignored, and the refill in progress keeps its line.
- R10: During and right after reset, all strobes, `busy` and `rowValid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Start a refill (taken only when idle) |
| reqAddr | input | ADDR_W-3 | Miss address, bits ADDR_W-1 down to 3 |
| reqZero | input | 1 | Request is a zero-line operation |
| busy | output | 1 | Refill in progress |
| wbCyc | output | 1 | Bus cycle |
| wbStb | output | 1 | Bus strobe |
| wbWe | output | 1 | Bus write enable |
| wbAdr | output | ADDR_W | Bus byte address |
| wbSel | output | 8 | Byte lane selects |
| wbDatO | output | 64 | Write data (always zero) |
| wbDatI | input | 64 | Read data |
| wbAck | input | 1 | Acknowledge |
| wbStall | input | 1 | Slave stall |
| ramWe | output | 1 | Data-RAM row write strobe |
| ramRow | output | log2(ROWS) | Row index for the RAM write |
| ramData | output | 64 | Row data for the RAM write |
| tagWe | output | 1 | Tag write strobe at the end of a refill |
| tagLine | output | ADDR_W-3-log2(ROWS) | Line number for the tag write |
| loadDone | output | 1 | Completion pulse |
| loadData | output | 64 | Forwarded data of the requested row |
| rowValid | output | ROWS | Per-row arrival flags of the current line |

## Verification
Some properties are checked on every cycle. The strobe implies the cycle signal. A completion pulse follows an acknowledge. Row flags never drop inside a refill and are clear at its start. Zero-line RAM writes carry zero data. The tag write happens only with the bus released. The wrap-around order, the pairing of each acknowledge with its row, the forwarded data values and the dropping of requests while busy need whole transactions. These are shown only by the bench's reference model. It compares the design against that model on every clock under varied critical rows, stall patterns and acknowledge latencies.

// File: rtl/refill_pkg.sv
package refill_pkg;
  localparam int ROW_BITS = 64;
  localparam int ROW_LSB  = 3;

  typedef struct packed {
    logic start;    // refill begins at this edge
    logic accept;   // a bus transfer is accepted at this edge
    logic takeAck;  // a row arrives at this edge
    logic fwd;      // the critical row of a load arrives
    logic zero;     // current refill is a zero-line operation
    logic busy;     // refill in progress
  } refill_strb_t;
endpackage

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
#(
  parameter int ROWS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqZero,
  input  logic         wbAck,
  input  logic         wbStall,
  output logic         wbCyc,
  output logic         wbStb,
  output logic         wbWe,
  output logic         busy,
  output logic         loadDone,
  output logic         tagWe,
  output refill_strb_t strb
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int CNT_W = ROW_W + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROWS - 1);

  logic busyQ, cycQ, stbQ, weQ, zeroQ, doneQ, tagQ;
  logic [CNT_W-1:0] issuedQ, ackedQ;
  logic start, accept, takeAck, firstAck, lastAck;

  assign start    = !busyQ && reqValid;
  assign accept   = stbQ && !wbStall;
  assign takeAck  = busyQ && wbAck;
  assign firstAck = takeAck && (ackedQ == '0);
  assign lastAck  = takeAck && (ackedQ == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      cycQ    <= 1'b0;
      stbQ    <= 1'b0;
      weQ     <= 1'b0;
      zeroQ   <= 1'b0;
      issuedQ <= '0;
      ackedQ  <= '0;
      doneQ   <= 1'b0;
      tagQ    <= 1'b0;
    end else begin
      doneQ <= (firstAck && !zeroQ) || (lastAck && zeroQ);
      tagQ  <= lastAck;
      if (start) begin
        busyQ   <= 1'b1;
        cycQ    <= 1'b1;
        stbQ    <= 1'b1;
        weQ     <= reqZero;
        zeroQ   <= reqZero;
        issuedQ <= '0;
        ackedQ  <= '0;
      end else if (busyQ) begin
        if (accept) begin
          issuedQ <= issuedQ + 1'b1;
          if (issuedQ == LAST) stbQ <= 1'b0;
        end
        if (takeAck) ackedQ <= ackedQ + 1'b1;
        if (lastAck) begin
          busyQ <= 1'b0;
          cycQ  <= 1'b0;
          stbQ  <= 1'b0;
        end
      end
    end
  end

  assign wbCyc    = cycQ;
  assign wbStb    = stbQ;
  assign wbWe     = weQ;
  assign busy     = busyQ;
  assign loadDone = doneQ;
  assign tagWe    = tagQ;

  assign strb.start   = start;
  assign strb.accept  = accept;
  assign strb.takeAck = takeAck;
  assign strb.fwd     = firstAck && !zeroQ;
  assign strb.zero    = zeroQ;
  assign strb.busy    = busyQ;

  p_stb_cyc_r1: assert property (@(posedge clk) disable iff (!rstN)
    wbStb |-> wbCyc);
  p_done_after_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> $past(wbAck));
  p_tag_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    tagWe |-> (!busy && !wbCyc));
endmodule

// File: rtl/refill_datapath.sv
module refill_datapath
  import refill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROWS   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  refill_strb_t                  strb,
  input  logic [ADDR_W-1:ROW_LSB]       reqAddr,
  input  logic [ROW_BITS-1:0]           wbDatI,
  output logic [ADDR_W-1:0]             wbAdr,
  output logic                          ramWe,
  output logic [$clog2(ROWS)-1:0]       ramRow,
  output logic [ROW_BITS-1:0]           ramData,
  output logic [ADDR_W-ROW_LSB-$clog2(ROWS)-1:0] tagLine,
  output logic [ROW_BITS-1:0]           loadData,
  output logic [ROWS-1:0]               rowValid
);
  localparam int ROW_W    = $clog2(ROWS);
  localparam int LINE_LSB = ROW_LSB + ROW_W;
  localparam int LINE_W   = ADDR_W - LINE_LSB;

  logic [LINE_W-1:0]   lineQ;
  logic [ROW_W-1:0]    issueRowQ, ackRowQ, ramRowQ;
  logic [ROWS-1:0]     rowValidQ;
  logic                ramWeQ;
  logic [ROW_BITS-1:0] ramDataQ, loadDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ     <= '0;
      issueRowQ <= '0;
      ackRowQ   <= '0;
      ramRowQ   <= '0;
      rowValidQ <= '0;
      ramWeQ    <= 1'b0;
      ramDataQ  <= '0;
      loadDataQ <= '0;
    end else begin
      ramWeQ <= 1'b0;
      if (strb.start) begin
        lineQ     <= reqAddr[ADDR_W-1:LINE_LSB];
        issueRowQ <= reqAddr[LINE_LSB-1:ROW_LSB];
        ackRowQ   <= reqAddr[LINE_LSB-1:ROW_LSB];
        rowValidQ <= '0;
      end else begin
        if (strb.accept) issueRowQ <= issueRowQ + 1'b1;
        if (strb.takeAck) begin
          rowValidQ[ackRowQ] <= 1'b1;
          ramWeQ   <= 1'b1;
          ramRowQ  <= ackRowQ;
          ramDataQ <= strb.zero ? '0 : wbDatI;
          ackRowQ  <= ackRowQ + 1'b1;
        end
        if (strb.fwd) loadDataQ <= wbDatI;
      end
    end
  end

  assign wbAdr    = {lineQ, issueRowQ, {ROW_LSB{1'b0}}};
  assign ramWe    = ramWeQ;
  assign ramRow   = ramRowQ;
  assign ramData  = ramDataQ;
  assign tagLine  = lineQ;
  assign loadData = loadDataQ;
  assign rowValid = rowValidQ;

  p_zero_ram_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && strb.zero) |-> (ramData == '0));
  p_valid_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && $past(strb.busy)) |-> ((rowValid & $past(rowValid)) == $past(rowValid)));
  p_clear_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.busy) |-> (rowValid == '0));
endmodule

// File: rtl/refill_engine.sv
module refill_engine
  import refill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROWS   = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  input  logic [ADDR_W-1:3]              reqAddr,
  input  logic                           reqZero,
  output logic                           busy,
  output logic                           wbCyc,
  output logic                           wbStb,
  output logic                           wbWe,
  output logic [ADDR_W-1:0]              wbAdr,
  output logic [7:0]                     wbSel,
  output logic [63:0]                    wbDatO,
  input  logic [63:0]                    wbDatI,
  input  logic                           wbAck,
  input  logic                           wbStall,
  output logic                           ramWe,
  output logic [$clog2(ROWS)-1:0]        ramRow,
  output logic [63:0]                    ramData,
  output logic                           tagWe,
  output logic [ADDR_W-4-$clog2(ROWS):0] tagLine,
  output logic                           loadDone,
  output logic [63:0]                    loadData,
  output logic [ROWS-1:0]                rowValid
);
  refill_strb_t strb;

  // Loads fetch every lane; zero-line writes fill every lane with zero.
  assign wbSel  = '1;
  assign wbDatO = '0;

  refill_ctrl #(.ROWS(ROWS)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqZero(reqZero),
    .wbAck(wbAck), .wbStall(wbStall), .wbCyc(wbCyc), .wbStb(wbStb),
    .wbWe(wbWe), .busy(busy), .loadDone(loadDone), .tagWe(tagWe),
    .strb(strb)
  );

  refill_datapath #(.ADDR_W(ADDR_W), .ROWS(ROWS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .wbDatI(wbDatI), .wbAdr(wbAdr), .ramWe(ramWe), .ramRow(ramRow),
    .ramData(ramData), .tagLine(tagLine), .loadData(loadData),
    .rowValid(rowValid)
  );
endmodule

// File: tb/refill_engine_tb_top.sv
module refill_engine_tb_top;
  localparam int ADDR_W = 32;
  localparam int ROWS   = 8;
  localparam int ROW_W  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:3] reqAddr = '0;
  logic reqZero = 1'b0;
  logic [63:0] wbDatI = '0;
  logic wbAck = 1'b0;
  logic wbStall = 1'b0;

  logic busy, wbCyc, wbStb, wbWe, ramWe, tagWe, loadDone;
  logic [ADDR_W-1:0] wbAdr;
  logic [7:0] wbSel;
  logic [63:0] wbDatO, ramData, loadData;
  logic [ROW_W-1:0] ramRow;
  logic [ADDR_W-4-ROW_W:0] tagLine;
  logic [ROWS-1:0] rowValid;

  always #10 clk = ~clk;

  refill_engine #(.ADDR_W(ADDR_W), .ROWS(ROWS)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqZero(reqZero), .busy(busy), .wbCyc(wbCyc), .wbStb(wbStb),
    .wbWe(wbWe), .wbAdr(wbAdr), .wbSel(wbSel), .wbDatO(wbDatO),
    .wbDatI(wbDatI), .wbAck(wbAck), .wbStall(wbStall), .ramWe(ramWe),
    .ramRow(ramRow), .ramData(ramData), .tagWe(tagWe), .tagLine(tagLine),
    .loadDone(loadDone), .loadData(loadData), .rowValid(rowValid)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycle   = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cycle, act, exp);
    end
  endtask

  function automatic logic [63:0] mkData(input logic [31:0] a);
    return {a ^ 32'hA5A5_0000, ~a};
  endfunction

  // Behavioural reference model, advanced on every rising edge.
  int mBusy = 0, mCyc = 0, mStb = 0, mWe = 0, mZero = 0;
  int mIssued = 0, mAcked = 0, mCrit = 0;
  longint mLine = 0;
  int mRamWe = 0, mRamRow = 0, mDone = 0, mTagWe = 0;
  logic [63:0] mRamData = '0, mLoadData = '0;
  logic [ROWS-1:0] mValid = '0;

  function automatic logic [31:0] mAdr();
    return 32'((mLine * ROWS + (mCrit + mIssued) % ROWS) * 8);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mCyc = 0; mStb = 0; mWe = 0; mZero = 0; mIssued = 0;
      mAcked = 0; mCrit = 0; mLine = 0; mRamWe = 0; mRamRow = 0;
      mDone = 0; mTagWe = 0; mRamData = '0; mLoadData = '0; mValid = '0;
    end else begin
      mRamWe = 0; mDone = 0; mTagWe = 0;
      if (mBusy == 0) begin
        if (reqValid) begin
          mBusy = 1; mCyc = 1; mStb = 1; mWe = int'(reqZero); mZero = int'(reqZero);
          mLine = longint'(reqAddr) / ROWS; mCrit = int'(reqAddr) % ROWS;
          mIssued = 0; mAcked = 0; mValid = '0;
        end
      end else begin
        if (mStb == 1 && !wbStall) begin
          mIssued++;
          if (mIssued == ROWS) mStb = 0;
        end
        if (wbAck) begin
          mRamRow = (mCrit + mAcked) % ROWS;
          mValid[mRamRow] = 1'b1;
          mRamWe = 1;
          mRamData = (mZero == 1) ? 64'd0 : wbDatI;
          if (mAcked == 0 && mZero == 0) begin
            mDone = 1; mLoadData = wbDatI;
          end
          mAcked++;
          if (mAcked == ROWS) begin
            mBusy = 0; mCyc = 0; mStb = 0; mTagWe = 1;
            if (mZero == 1) mDone = 1;
          end
        end
      end
    end
  end

  // Bus slave: queued acknowledges with programmable latency and stalls.
  int lat = 1;
  int stallMode = 0;
  logic [7:0] lfsr = 8'h5B;
  logic [31:0] pendAddr[$];
  int pendDue[$];

  always @(negedge clk) begin
    cycle++;
    // compare against the model
    chk("R8 busy", 64'(busy), 64'(mBusy));
    chk("R1 wbCyc", 64'(wbCyc), 64'(mCyc));
    chk("R2 wbStb", 64'(wbStb), 64'(mStb));
    chk("R4 rowValid", 64'(rowValid), 64'(mValid));
    chk("R7 ramWe", 64'(ramWe), 64'(mRamWe));
    chk("R3 loadDone", 64'(loadDone), 64'(mDone));
    chk("R8 tagWe", 64'(tagWe), 64'(mTagWe));
    if (mStb == 1) begin
      chk("R2 wbAdr", 64'(wbAdr), 64'(mAdr()));
      chk("R1 wbSel", 64'(wbSel), 64'hFF);
      chk("R6 wbWe", 64'(wbWe), 64'(mWe));
      chk("R6 wbDatO", wbDatO, 64'd0);
    end
    if (mRamWe == 1) begin
      chk("R4 ramRow", 64'(ramRow), 64'(mRamRow));
      chk("R7 ramData", ramData, mRamData);
    end
    if (mDone == 1 && mZero == 0) chk("R3 loadData", loadData, mLoadData);
    if (mTagWe == 1) chk("R8 tagLine", 64'(tagLine), 64'(mLine));
    // drive slave for next edge
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wbAck = 1'b0;
    if (pendDue.size() > 0 && pendDue[0] <= cycle) begin
      wbAck = 1'b1;
      wbDatI = mkData(pendAddr[0]);
      void'(pendAddr.pop_front());
      void'(pendDue.pop_front());
    end
    wbStall = (stallMode != 0) && lfsr[0];
    if (rstN && wbStb && !wbStall) begin
      pendAddr.push_back(wbAdr);
      pendDue.push_back(cycle + lat);
    end
  end

  task automatic doReq(input logic [31:0] byteAddr, input logic zero);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = byteAddr[31:3];
    reqZero  = zero;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R5 rowValid cleared at start", 64'(rowValid), 64'd0);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset busy", 64'(busy), 64'd0);
    chk("R10 reset strobes", 64'({wbCyc, wbStb, ramWe, tagWe, loadDone}), 64'd0);
    chk("R10 reset rowValid", 64'(rowValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", 64'({busy, wbCyc, wbStb}), 64'd0);

    lat = 1; stallMode = 0;
    doReq(32'h0000_1000, 1'b0);       // critical row 0
    lat = 3;
    doReq(32'h0000_2468, 1'b0);       // critical row 5, wraps
    stallMode = 1; lat = 2;
    doReq(32'h0000_3078, 1'b1);       // zero-line from row 7
    lat = 4;
    doReq(32'h0000_4050, 1'b0);       // row 2 with stalls
    doReq(32'h0000_5008, 1'b1);       // zero-line row 1 with stalls

    // R9: a request while busy must be dropped
    stallMode = 0; lat = 2;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 29'(32'h0000_6030 >> 3); reqZero = 1'b0;
    @(negedge clk);
    reqAddr = 29'(32'h0000_7FF8 >> 3); reqZero = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R9 line kept while busy", 64'(wbAdr[31:6]), 64'(32'h0000_6030 >> 6));
    chk("R9 write flag kept", 64'(wbWe), 64'd0);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R9 no second refill", 64'(busy), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule